// File: doc/BRIEF.md
# Battery Pre-Charge Pulse Controller

This block takes care of a lithium cell while the host processor is unpowered. When an external charger is plugged in and the cell sits under its deep-discharge threshold, it drives the gate of the external pass transistor in short pulses: one window of a fixed length per frame, both counted in millisecond ticks. An open-drain indicator LED is lit in the same window, so a user sees that charging is under way with the phone off. The pulsing stops in hardware once the cell reaches its upper pre-charge threshold, or when the charger is unplugged.

Once the host is powered it takes over by raising its charge command. From then on the gate follows that command directly and the LED follows the host's LED command, which lets software run fast and pulsed charging. If the host comes up during pre-charge but never takes over, a watchdog counts ticks and, at the timeout, emits a one-cycle expiry pulse that the surrounding logic uses to pull the reset line low and shut the device down. The block then holds its outputs off until the host supply drops.

The threshold flags come from analog comparators. The pulse width, frame length and watchdog timeout are parameters in ticks. With the defaults they are 100 ms, 1 s and 10 s.

Top module: `pchg_pulse_ctrl`

## Requirements
- R1: After reset, gateEn, ledEn and wdExpire are all low and the block is idle.
- R2: Pre-charge starts only from idle with chargerPresent high, hostOn low and batLow high. The first pulse window begins on the cycle after entry. With hostOn high the block enters host control instead.
- R3: During pre-charge gateEn is high while the frame count, advanced by one on each msTick and wrapping after PULSE_PERIOD_MS ticks, is below PULSE_ON_MS.
- R4: During pre-charge ledEn equals gateEn. chgCmd and ledCmd have no effect while hostOn is low.
- R5: batHigh high during pre-charge returns the block to idle on the next clock edge, with gateEn and ledEn low. It stays idle while batLow is low.
- R6: With hostOn and chgCmd both high during pre-charge, the next edge hands over to host control. There gateEn equals chgCmd and ledEn equals ledCmd in the same cycle, until hostOn falls.
- R7: chargerPresent low forces gateEn and ledEn low in any state, and the block returns to idle.
- R8: While pre-charge runs with hostOn high and no takeover, the watchdog counts msTick. On the WDOG_MS-th tick, wdExpire is high for exactly one cycle. gateEn and ledEn then stay low until hostOn falls.
- R9: The watchdog never fires while hostOn is low.
- R10: In idle with the charger present, gateEn is low and ledEn follows ledCmd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-cycle strobe per millisecond |
| hostOn | input | 1 | Host processor is powered |
| chgCmd | input | 1 | Host charge command (low when undriven) |
| ledCmd | input | 1 | Host LED command (low when undriven) |
| chargerPresent | input | 1 | Adapter detected |
| batLow | input | 1 | Cell below the pre-charge entry threshold |
| batHigh | input | 1 | Cell above the pre-charge stop threshold |
| gateEn | output | 1 | Pass-transistor gate enable |
| ledEn | output | 1 | Open-drain LED sink enable |
| wdExpire | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The hardest case to reach is the watchdog expiry. It needs the host to be powered while pre-charge is still running, which only happens when hostOn rises after pre-charge has begun and chgCmd stays low for the whole timeout. The bench first enters pre-charge with the host off. It then raises hostOn and issues a tick every cycle with small timing parameters, so the frame wraps several times before the expiry. This checks the gate pulse train and the exact expiry cycle in the same run. After that it checks that the outputs stay off until the host supply drops and that pre-charge can restart.

// File: rtl/pchg_pkg.sv
package pchg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_HOST = 2'd2,
    ST_SHUT = 2'd3
  } pchgState_t;

  typedef struct packed {
    logic frameClr;
    logic frameRun;
    logic wdClr;
    logic wdRun;
  } pchgStrobe_t;

endpackage

// File: rtl/pchg_timer.sv
module pchg_timer
  import pchg_pkg::*;
#(
  parameter int PULSE_ON_MS     = 100,
  parameter int PULSE_PERIOD_MS = 1000,
  parameter int WDOG_MS         = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        msTick,
  input  pchgStrobe_t strobe,
  output logic        pulseWin,
  output logic        wdDone
);

  localparam int FRAME_W = $clog2(PULSE_PERIOD_MS + 1);
  localparam int WD_W    = $clog2(WDOG_MS + 1);
  localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(PULSE_PERIOD_MS - 1);
  localparam logic [FRAME_W-1:0] ON_LIMIT   = FRAME_W'(PULSE_ON_MS);
  localparam logic [WD_W-1:0]    WD_LAST    = WD_W'(WDOG_MS - 1);

  logic [FRAME_W-1:0] frameCnt;
  logic [WD_W-1:0]    wdCnt;

  // Frame counter: shared by gate pulse and LED blink
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (strobe.frameClr) begin
      frameCnt <= '0;
    end else if (strobe.frameRun && msTick) begin
      if (frameCnt == FRAME_LAST) frameCnt <= '0;
      else                        frameCnt <= frameCnt + 1'b1;
    end
  end

  assign pulseWin = (frameCnt < ON_LIMIT);

  // Takeover watchdog: saturates at its last count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (strobe.wdClr) begin
      wdCnt <= '0;
    end else if (strobe.wdRun && msTick && (wdCnt != WD_LAST)) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  assign wdDone = strobe.wdRun && msTick && (wdCnt == WD_LAST);

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= FRAME_LAST); // R3
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.frameClr && strobe.frameRun && msTick && frameCnt == FRAME_LAST)
      |=> (frameCnt == '0)); // R3
  AST_WD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt <= WD_LAST); // R8
  AST_WD_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wdClr |=> (wdCnt == '0)); // R9

endmodule

// File: rtl/pchg_ctrl.sv
module pchg_ctrl
  import pchg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostOn,
  input  logic        chgCmd,
  input  logic        ledCmd,
  input  logic        chargerPresent,
  input  logic        batLow,
  input  logic        batHigh,
  input  logic        pulseWin,
  input  logic        wdDone,
  output pchgStrobe_t strobe,
  output logic        gateEn,
  output logic        ledEn,
  output logic        wdExpire
);

  pchgState_t state;
  pchgState_t stateNxt;
  logic       takeover;
  logic       wdFire;
  logic       gateRaw;
  logic       ledRaw;

  assign takeover = hostOn && chgCmd;
  assign wdFire   = (state == ST_PRE) && chargerPresent && !takeover && wdDone;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (chargerPresent && hostOn)                     stateNxt = ST_HOST;
        else if (chargerPresent && batLow && !batHigh)    stateNxt = ST_PRE;
      end
      ST_PRE: begin
        if (!chargerPresent)  stateNxt = ST_IDLE;
        else if (takeover)    stateNxt = ST_HOST;
        else if (wdDone)      stateNxt = ST_SHUT;
        else if (batHigh)     stateNxt = ST_IDLE;
      end
      ST_HOST: begin
        if (!hostOn || !chargerPresent) stateNxt = ST_IDLE;
      end
      ST_SHUT: begin
        if (!hostOn) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wdExpire <= 1'b0;
    end else begin
      state    <= stateNxt;
      wdExpire <= wdFire;
    end
  end

  always_comb begin
    strobe.frameRun = (state == ST_PRE);
    strobe.frameClr = (state != ST_PRE);
    strobe.wdRun    = (state == ST_PRE) && hostOn;
    strobe.wdClr    = !((state == ST_PRE) && hostOn);
  end

  always_comb begin
    gateRaw = 1'b0;
    ledRaw  = 1'b0;
    unique case (state)
      ST_PRE:  begin gateRaw = pulseWin; ledRaw = pulseWin; end
      ST_HOST: begin gateRaw = chgCmd;   ledRaw = ledCmd;   end
      ST_IDLE: begin gateRaw = 1'b0;     ledRaw = ledCmd;   end
      default: begin gateRaw = 1'b0;     ledRaw = 1'b0;     end
    endcase
  end

  assign gateEn = gateRaw && chargerPresent;
  assign ledEn  = ledRaw && chargerPresent;

  AST_NO_CHARGER_NO_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !chargerPresent |-> (!gateEn && !ledEn)); // R7
  AST_WD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |=> !wdExpire); // R8
  AST_WD_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |-> (!gateEn && !ledEn)); // R8
  AST_WD_HOST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !hostOn |=> !wdExpire); // R9
  AST_BATHIGH_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PRE) && chargerPresent && !takeover && !wdDone && batHigh)
      |=> (state == ST_IDLE)); // R5
  AST_PRE_LED_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE) |-> (ledEn == gateEn)); // R4

endmodule

// File: rtl/pchg_pulse_ctrl.sv
module pchg_pulse_ctrl
  import pchg_pkg::*;
#(
  parameter int PULSE_ON_MS     = 100,
  parameter int PULSE_PERIOD_MS = 1000,
  parameter int WDOG_MS         = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic hostOn,
  input  logic chgCmd,
  input  logic ledCmd,
  input  logic chargerPresent,
  input  logic batLow,
  input  logic batHigh,
  output logic gateEn,
  output logic ledEn,
  output logic wdExpire
);

  pchgStrobe_t strobe;
  logic        pulseWin;
  logic        wdDone;

  pchg_timer #(
    .PULSE_ON_MS    (PULSE_ON_MS),
    .PULSE_PERIOD_MS(PULSE_PERIOD_MS),
    .WDOG_MS        (WDOG_MS)
  ) uTimer (
    .clk     (clk),
    .rstN    (rstN),
    .msTick  (msTick),
    .strobe  (strobe),
    .pulseWin(pulseWin),
    .wdDone  (wdDone)
  );

  pchg_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .hostOn        (hostOn),
    .chgCmd        (chgCmd),
    .ledCmd        (ledCmd),
    .chargerPresent(chargerPresent),
    .batLow        (batLow),
    .batHigh       (batHigh),
    .pulseWin      (pulseWin),
    .wdDone        (wdDone),
    .strobe        (strobe),
    .gateEn        (gateEn),
    .ledEn         (ledEn),
    .wdExpire      (wdExpire)
  );

endmodule

// File: tb/tb_pchg_pulse_ctrl.sv
`timescale 1ns/1ps
module tb_pchg_pulse_ctrl;

  localparam int ON_T  = 3;
  localparam int PER_T = 8;
  localparam int WD_T  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, hostOn = 1'b0, chgCmd = 1'b0, ledCmd = 1'b0;
  logic chargerPresent = 1'b0, batLow = 1'b0, batHigh = 1'b0;
  logic gateEn, ledEn, wdExpire;

  typedef struct {
    logic  g;
    logic  l;
    logic  w;
    string tag;
  } expItem_t;

  expItem_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pchg_pulse_ctrl #(
    .PULSE_ON_MS(ON_T), .PULSE_PERIOD_MS(PER_T), .WDOG_MS(WD_T)
  ) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .hostOn(hostOn),
    .chgCmd(chgCmd), .ledCmd(ledCmd), .chargerPresent(chargerPresent),
    .batLow(batLow), .batHigh(batHigh),
    .gateEn(gateEn), .ledEn(ledEn), .wdExpire(wdExpire)
  );

  // Driver: apply one cycle of inputs, queue what must appear after the edge
  task automatic cyc(input logic tk, input logic ho, input logic cc, input logic lc,
                     input logic cp, input logic bl, input logic bh,
                     input logic eg, input logic el, input logic ew, input string tag);
    expItem_t it;
    @(negedge clk);
    msTick = tk; hostOn = ho; chgCmd = cc; ledCmd = lc;
    chargerPresent = cp; batLow = bl; batHigh = bh;
    it.g = eg; it.l = el; it.w = ew; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        expItem_t it;
        it = q.pop_front();
        nChecks++;
        if (gateEn !== it.g || ledEn !== it.l || wdExpire !== it.w) begin
          nFails++;
          $display("FAIL %s: got gate=%b led=%b wd=%b expected gate=%b led=%b wd=%b",
                   it.tag, gateEn, ledEn, wdExpire, it.g, it.l, it.w);
        end
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got hung run expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    cyc(0,0,0,0,0,0,0, 0,0,0, "R1");
    // R7: LED command ignored without charger
    cyc(0,0,0,1,0,0,0, 0,0,0, "R7");
    // R10: idle with charger, LED follows command, gate low
    cyc(0,0,0,1,1,0,0, 0,1,0, "R10");
    cyc(0,0,1,0,1,0,0, 0,0,0, "R10");
    // R2: enter pre-charge, first window immediately
    cyc(0,0,0,0,1,1,0, 1,1,0, "R2");
    // R3/R4/R9: pulse train, commands ignored, no watchdog with host off
    for (int i = 1; i <= 20; i++) begin
      logic e;
      e = ((i % PER_T) < ON_T);
      cyc(1,0,1,logic'(i[0]),1,1,0, e,e,0, "R3 R4 R9");
    end
    // R5: upper threshold stops pre-charge, stays idle
    cyc(0,0,0,0,1,0,1, 0,0,0, "R5");
    cyc(1,0,0,0,1,0,0, 0,0,0, "R5");
    // R2 again, then R7: charger removal
    cyc(0,0,0,0,1,1,0, 1,1,0, "R2");
    cyc(0,0,0,1,0,1,0, 0,0,0, "R7");
    cyc(0,0,0,0,0,1,0, 0,0,0, "R7");
    // R2: host powered at entry goes to host control, not pre-charge
    cyc(0,1,0,0,1,1,0, 0,0,0, "R2");
    cyc(0,0,0,0,1,0,0, 0,0,0, "R2");
    // R6: takeover
    cyc(0,0,0,0,1,1,0, 1,1,0, "R6");
    cyc(1,1,0,0,1,1,0, 1,1,0, "R6");
    cyc(1,1,0,0,1,1,0, 1,1,0, "R6");
    cyc(1,1,0,0,1,1,0, 0,0,0, "R6");
    cyc(0,1,1,0,1,1,0, 1,0,0, "R6");
    cyc(0,1,0,1,1,1,0, 0,1,0, "R6");
    cyc(1,1,1,0,1,1,0, 1,0,0, "R6");
    cyc(0,0,0,0,1,0,0, 0,0,0, "R6");
    // R8: watchdog expiry with host up and no takeover
    cyc(0,0,0,0,1,1,0, 1,1,0, "R8");
    for (int i = 1; i < WD_T; i++) begin
      logic e;
      e = ((i % PER_T) < ON_T);
      cyc(1,1,0,0,1,1,0, e,e,0, "R8");
    end
    cyc(1,1,0,0,1,1,0, 0,0,1, "R8");
    cyc(1,1,0,1,1,1,0, 0,0,0, "R8");
    cyc(0,1,1,1,1,1,0, 0,0,0, "R8");
    cyc(0,0,0,0,1,1,0, 0,0,0, "R8");
    cyc(0,0,0,0,1,1,0, 1,1,0, "R2");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    finishRun();
  end

endmodule